// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block runs the timing of an external dual-slope integrating converter. After a start request it goes through a fixed sequence. First it closes the zeroing switch so the integrator settles at 0 V. Next it connects the input signal to the integrator for a fixed number of clock cycles. It then switches the integrator onto a reference of the opposite polarity and counts cycles until the comparator shows that the integrator has crossed back through zero. The count is proportional to the magnitude of the input, because V_in = V_ref × T_deint / T_int. Set the integration window to a whole number of mains periods so that line-frequency pickup averages out. For example, 0.1 s covers both 50 Hz and 60 Hz.

The controller has five states:
- ST_IDLE: waits for a start request.
- ST_ZERO: the zeroing switch is on for `ZERO_CYCLES` cycles.
- ST_INTEG: the signal switch is on for `INT_CYCLES` cycles.
- ST_DEINT: the reference switch is on until a comparator edge, or until the `MAX_DEINT` limit.
- ST_FINISH: a single cycle that carries the done pulse.

The transitions are:
- idle→zero on start.
- zero→integ when the zeroing count is reached.
- integ→deint on the last integration cycle.
- deint→finish on a synchronized comparator edge or when the limit is reached.
- finish→idle unconditionally.

The result is a two's-complement word. Its sign comes from the input polarity, which is latched at the end of integration. If the comparator never turns, the result is saturated and the overrange flag is raised.

Top module: `dslope_seq_ctrl`

## Requirements
- R1: After reset, all switch outputs, `busy_o`, `done_o`, `ovr_o` are 0 and `result_o` is 0.
- R2: A `start_i` high in ST_IDLE enters ST_ZERO on the next edge. `zero_sw_o` then stays high for exactly `ZERO_CYCLES` cycles. `start_i` has no effect while `busy_o` is high: phase lengths are unchanged and no extra conversion follows.
- R3: `sig_sw_o` is high for exactly `INT_CYCLES` cycles. `ref_sw_o` is high in the very next cycle, with no gap. At most one of the three switch outputs is high at any time.
- R4: `pol_neg_i` is sampled on the last integration cycle (1 = negative input). During de-integration `ref_neg_o` = 1 exactly when the latched polarity is positive. Changes of `pol_neg_i` after that sample have no effect on `ref_neg_o` or on the result.
- R5: `cmp_i` passes through a two-stage synchronizer, and a change in either direction ends de-integration. The magnitude is the number of de-integration cycles before the cycle in which the synchronized edge is seen. A change applied just after the D-th rising edge following de-integration entry gives magnitude D+2.
- R6: Comparator changes outside de-integration (during integration, or after the limit) do not end or alter a conversion.
- R7: `result_o` equals +magnitude when the latched polarity is positive and −magnitude (two's complement) when it is negative.
- R8: With no edge within `MAX_DEINT` de-integration cycles, the conversion ends with `ovr_o`=1 and magnitude `MAX_DEINT`. An edge seen in the last allowed cycle wins and gives magnitude `MAX_DEINT`−1 with `ovr_o`=0.
- R9: `done_o` is a one-cycle pulse in the cycle after de-integration ends, and `busy_o` drops after it. `result_o` and `ovr_o` change only together with `done_o` and hold until the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, honoured only when idle |
| cmp_i | input | 1 | Comparator level (asynchronous) |
| pol_neg_i | input | 1 | Input polarity, 1 = negative |
| zero_sw_o | output | 1 | Zeroing switch enable |
| sig_sw_o | output | 1 | Input-signal switch enable |
| ref_sw_o | output | 1 | Reference switch enable |
| ref_neg_o | output | 1 | Reference polarity select, 1 = negative reference |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result-valid strobe |
| ovr_o | output | 1 | Overrange flag of the last result |
| result_o | output | RES_W | Signed de-integration count |

## Verification
The hardest situation to reach is a comparator edge that lands exactly on the final allowed de-integration cycle, and its neighbour one cycle later, which must turn into an overrange. The bench times the comparator toggle in whole clock cycles from the first cycle in which `ref_sw_o` is seen high. Using a small limit, it places the toggle D = `MAX_DEINT`−3 and `MAX_DEINT`−2 cycles after that point. The late toggle then also serves as a stray comparator edge that the following conversion must ignore. A second such stray edge is injected mid-integration.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ZERO,
        ST_INTEG,
        ST_DEINT,
        ST_FINISH
    } seq_state_t;

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dslope_cmp_sync.sv
module dslope_cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_i,
    output logic toggle_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= cmp_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], cmp_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign toggle_o = chain_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/dslope_phase_cnt.sv
module dslope_phase_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_o <= '0;
        else if (clr_i)      cnt_o <= '0;
        else if (cnt_o != '1) cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/dslope_result.sv
module dslope_result #(
    parameter int MAG_W   = 8,
    parameter int MAG_MAX = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             ovr_i,
    input  logic             neg_i,
    input  logic [MAG_W-1:0] mag_i,
    output logic [MAG_W:0]   result_o,
    output logic             ovr_o
);
    logic [MAG_W:0] mag_ext;

    always_comb begin
        if (ovr_i) mag_ext = (MAG_W+1)'(MAG_MAX);
        else       mag_ext = {1'b0, mag_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            ovr_o    <= 1'b0;
        end else if (load_i) begin
            result_o <= neg_i ? (~mag_ext + 1'b1) : mag_ext;
            ovr_o    <= ovr_i;
        end
    end
endmodule

// File: rtl/dslope_seq_ctrl.sv
module dslope_seq_ctrl
    import dslope_pkg::*;
#(
    parameter int ZERO_CYCLES = 1000,
    parameter int INT_CYCLES  = 100000,
    parameter int MAX_DEINT   = 2 * INT_CYCLES,
    parameter int SYNC_STAGES = 2,
    localparam int MAG_W      = $clog2(MAX_DEINT + 1),
    localparam int RES_W      = MAG_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    input  logic             pol_neg_i,
    output logic             zero_sw_o,
    output logic             sig_sw_o,
    output logic             ref_sw_o,
    output logic             ref_neg_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             ovr_o,
    output logic [RES_W-1:0] result_o
);
    localparam int PH_MAX = max_of3(ZERO_CYCLES, INT_CYCLES, MAX_DEINT);
    localparam int PH_W   = $clog2(PH_MAX + 1);

    seq_state_t      state_q, state_n;
    logic [PH_W-1:0] ph_cnt;
    logic            ph_clr;
    logic            cmp_edge;
    logic            pol_q;
    logic            zero_last, int_last, deint_last;
    logic            res_load;

    dslope_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_i    (cmp_i),
        .toggle_o (cmp_edge)
    );

    dslope_phase_cnt #(.W(PH_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (ph_clr),
        .cnt_o (ph_cnt)
    );

    assign zero_last  = (ph_cnt == PH_W'(ZERO_CYCLES - 1));
    assign int_last   = (ph_cnt == PH_W'(INT_CYCLES - 1));
    assign deint_last = (ph_cnt == PH_W'(MAX_DEINT - 1));

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)               state_n = ST_ZERO;
            ST_ZERO:   if (zero_last)             state_n = ST_INTEG;
            ST_INTEG:  if (int_last)              state_n = ST_DEINT;
            ST_DEINT:  if (cmp_edge || deint_last) state_n = ST_FINISH;
            ST_FINISH:                            state_n = ST_IDLE;
            default:                              state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    assign ph_clr = (state_n != state_q);

    // polarity sampled on the final integration cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          pol_q <= 1'b0;
        else if (state_q == ST_INTEG && int_last) pol_q <= pol_neg_i;
    end

    assign res_load = (state_q == ST_DEINT) && (state_n == ST_FINISH);

    dslope_result #(.MAG_W(MAG_W), .MAG_MAX(MAX_DEINT)) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (res_load),
        .ovr_i    (!cmp_edge),
        .neg_i    (pol_q),
        .mag_i    (MAG_W'(ph_cnt)),
        .result_o (result_o),
        .ovr_o    (ovr_o)
    );

    // state-decoded outputs
    always_comb begin
        zero_sw_o = 1'b0;
        sig_sw_o  = 1'b0;
        ref_sw_o  = 1'b0;
        ref_neg_o = 1'b0;
        busy_o    = 1'b1;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy_o    = 1'b0;
            ST_ZERO:   zero_sw_o = 1'b1;
            ST_INTEG:  sig_sw_o  = 1'b1;
            ST_DEINT: begin
                ref_sw_o  = 1'b1;
                ref_neg_o = !pol_q;
            end
            ST_FINISH: done_o    = 1'b1;
            default:   busy_o    = 1'b0;
        endcase
    end

endmodule

// File: rtl/dslope_chk.sv
module dslope_chk #(
    parameter int RES_W   = 8,
    parameter int MAG_MAX = 200
) (
    input logic             clk,
    input logic             rst_n,
    input logic             zero_sw_o,
    input logic             sig_sw_o,
    input logic             ref_sw_o,
    input logic             ref_neg_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             ovr_o,
    input logic [RES_W-1:0] result_o
);
    localparam logic [RES_W-1:0] SAT_POS = RES_W'(MAG_MAX);
    localparam logic [RES_W-1:0] SAT_NEG = RES_W'(-MAG_MAX);

    assert_zero_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zero_sw_o) |-> !$past(busy_o));

    assert_one_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({zero_sw_o, sig_sw_o, ref_sw_o}));

    assert_no_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sig_sw_o) |-> ref_sw_o);

    assert_refneg_in_deint_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ref_neg_o |-> ref_sw_o);

    assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovr_o) |-> (result_o == SAT_POS || result_o == SAT_NEG));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(result_o) || !$stable(ovr_o)) |-> done_o);

endmodule

bind dslope_seq_ctrl dslope_chk #(.RES_W(RES_W), .MAG_MAX(MAX_DEINT)) u_dslope_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .zero_sw_o (zero_sw_o),
    .sig_sw_o  (sig_sw_o),
    .ref_sw_o  (ref_sw_o),
    .ref_neg_o (ref_neg_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .ovr_o     (ovr_o),
    .result_o  (result_o)
);

// File: tb/test_dslope_seq_ctrl.sv
module test_dslope_seq_ctrl;
    localparam int ZC  = 5;
    localparam int IC  = 20;
    localparam int MX  = 40;
    localparam int RW  = $clog2(MX + 1) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic cmp_i = 1'b0;
    logic pol_neg_i = 1'b0;
    logic zero_sw_o, sig_sw_o, ref_sw_o, ref_neg_o, busy_o, done_o, ovr_o;
    logic [RW-1:0] result_o;

    int checks = 0;
    int errors = 0;
    int q_res[$];
    bit q_ovr[$];

    always #5 clk = ~clk;

    dslope_seq_ctrl #(.ZERO_CYCLES(ZC), .INT_CYCLES(IC), .MAX_DEINT(MX)) i_dslope_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i), .pol_neg_i(pol_neg_i),
        .zero_sw_o(zero_sw_o), .sig_sw_o(sig_sw_o), .ref_sw_o(ref_sw_o), .ref_neg_o(ref_neg_o),
        .busy_o(busy_o), .done_o(done_o), .ovr_o(ovr_o), .result_o(result_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops expected results as done pulses appear (R5 R7 R8 R9)
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (q_res.size() == 0) begin
                check(1'b0, "R9 unexpected done", 1, 0);
            end else begin
                int er;
                bit eo;
                er = q_res.pop_front();
                eo = q_ovr.pop_front();
                check($signed(result_o) == er, "R5/R7/R8 result", $signed(result_o), er);
                check(ovr_o == eo, "R8 overrange flag", ovr_o, eo);
            end
        end
    end

    // driver: d < 0 means no comparator change during de-integration
    task automatic conv(input bit neg, input int d, input bit pre_tog, input bit flip_late);
        int n;
        int mag;
        bit ov;
        ov  = (d < 0) || (d + 2 > MX - 1);
        mag = ov ? MX : d + 2;
        q_res.push_back(neg ? -mag : mag);
        q_ovr.push_back(ov);

        pol_neg_i = neg;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        n = 0;
        while (zero_sw_o && n < 1000) begin n++; @(negedge clk); end
        check(n == ZC, "R2 zeroing length", n, ZC);
        n = 0;
        while (sig_sw_o && n < 1000) begin
            if (n == 2) begin
                start_i = 1'b1;              // R2: ignored while busy
                if (pre_tog) cmp_i = ~cmp_i; // R6: edge during integration
            end else begin
                start_i = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        start_i = 1'b0;
        check(n == IC, "R3 integration length", n, IC);
        check(ref_sw_o == 1'b1, "R3 no gap before de-integration", ref_sw_o, 1);
        check(ref_neg_o == !neg, "R4 reference polarity", ref_neg_o, !neg);
        if (flip_late) begin
            pol_neg_i = ~neg;
            @(negedge clk);
            check(ref_neg_o == !neg, "R4 late polarity change ignored", ref_neg_o, !neg);
            d = d - 1;
        end
        if (d >= 0) begin
            repeat (d) @(negedge clk);
            cmp_i = ~cmp_i;
        end
        n = 0;
        while (busy_o && n < 1000) begin n++; @(negedge clk); end
        @(negedge clk);
        check(!busy_o && !zero_sw_o, "R2 no restart from ignored start", busy_o, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!zero_sw_o && !sig_sw_o && !ref_sw_o && !busy_o && !done_o, "R1 reset outputs", busy_o, 0);
        check(result_o == '0 && !ovr_o, "R1 reset result", result_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        conv(1'b0, 0,  1'b0, 1'b0);   // R5 minimum count, rising comparator
        conv(1'b1, 5,  1'b0, 1'b0);   // R7 negative, falling comparator
        conv(1'b0, 17, 1'b1, 1'b0);   // R6 stray edge during integration
        conv(1'b1, 12, 1'b0, 1'b1);   // R4 polarity flip after sample
        conv(1'b0, MX - 3, 1'b0, 1'b0); // R8 edge in last allowed cycle
        conv(1'b1, MX - 2, 1'b0, 1'b0); // R8 edge one cycle too late -> overrange
        conv(1'b0, 9,  1'b0, 1'b0);   // R6 late edge above must not leak
        conv(1'b0, -1, 1'b0, 1'b0);   // R8 no edge at all

        check(q_res.size() == 0, "R9 all results delivered", q_res.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule